// File: doc/BRIEF.md
# SPI Serial Memory Slave

This block is the serial front end of a small byte-addressed memory. The memory is held in an internal register array. A host drives a serial clock, an active-low select and a data input. The block answers on a data output that has its own output enable, so a pad or a shared line can be left undriven. Inside each select window, the first byte is the command. Memory commands then take a two-byte address, and after that any number of data bytes follow. The address steps through the array on each byte until the host releases the select.

A status byte holds a write-enable latch and two protect bits that fence off the upper part of the array. It also holds one spare flag that software can write. The host sets and clears the latch with dedicated commands, and the latch guards both memory writes and status writes. An unknown command makes the block deaf and silent until the select is next asserted.

The serial pins are sampled by the system clock through synchronizers. The serial clock must therefore run well below the system clock. Both idle polarities of the serial clock are accepted.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset the status byte reads 0x00, and `so_oe` is low whenever `cs_n` is high.
- R2: The first byte after `cs_n` falls is the command. 0x06 sets status bit 1 (the write-enable latch) and 0x04 clears it. 0x05 returns the status byte on `so`, most significant bit first, and returns it again for every further byte clocked.
- R3: Command 0x01 takes one data byte. When the latch is set, bit 7 and bits 3:2 of that byte are loaded into the status byte. Status bits 6:4 and bit 0 always read 0. When the latch is clear, the byte has no effect.
- R4: The latch only rises on a completed 0x06 command byte. It is cleared when `cs_n` rises after a 0x01 or 0x02 transaction that received at least one full data byte.
- R5: Command 0x03 is followed by a 16-bit address, most significant bit first, of which only the low ADDR_BITS bits are used. Data then leaves on `so`, most significant bit first, with `so_oe` high. `so` changes only after serial clock falling edges.
- R6: Command 0x02 is followed by a 16-bit address. Each complete data byte is then stored when the latch is set, and it is discarded when the latch is clear.
- R7: During 0x03 and 0x02 transfers the address advances by one per byte and wraps from the top of the array to 0.
- R8: Status bits 3:2 protect part of the array against 0x02 writes. A value of 01 protects the top quarter, 10 protects the top half, and 11 protects the whole array.
- R9: On any other command byte, all later input bits are ignored and `so_oe` stays low until the next `cs_n` falling edge.
- R10: Raising `cs_n` at any point drops a partly received byte, turns `so_oe` off, and makes the next transaction start with a command byte.
- R11: Input bits are taken on serial clock rising edges with `cs_n` low. When the clock idles high as `cs_n` falls (mode 3), the level at the select edge is not counted as a rising edge; in mode 0 the clock idles low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | High while `so` is to be driven |

## Verification
The bench builds the block with ADDR_BITS = 4, which gives a 16-byte array. At that size one write burst fills every location and a read of twenty bytes crosses the wrap point. The bench sweeps all four protect settings over every address and checks each byte against a model in the bench. The 16-bit addresses it sends carry ones in the ignored upper bits. The bench alternates the two clock modes between transactions.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 3;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRIT = 8'h02;

  typedef enum logic [3:0] {
    ST_CMD,
    ST_AHI,
    ST_ALO,
    ST_RD,
    ST_WR,
    ST_WRSR,
    ST_SROUT,
    ST_IDLE,
    ST_LOCK
  } cmd_state_e;

  // Protect decode: guard code against the two top address bits.
  function automatic logic block_hit(input logic [1:0] guard, input logic [1:0] top2);
    case (guard)
      2'b00:   block_hit = 1'b0;
      2'b01:   block_hit = (top2 == 2'b11);
      2'b10:   block_hit = top2[1];
      default: block_hit = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic si_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_idle,
  output logic si_s
);
  logic [STAGES-1:0] sck_ff, cs_ff, si_ff;
  logic              sck_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_ff <= '0;
      cs_ff  <= '1;
      si_ff  <= '0;
      sck_p  <= 1'b0;
    end else begin
      sck_ff <= {sck_ff[STAGES-2:0], sck_i};
      cs_ff  <= {cs_ff[STAGES-2:0], cs_n_i};
      si_ff  <= {si_ff[STAGES-2:0], si_i};
      sck_p  <= sck_ff[STAGES-1];
    end
  end

  assign cs_idle  = cs_ff[STAGES-1];
  assign si_s     = si_ff[STAGES-1];
  assign sck_rise = sck_ff[STAGES-1] & ~sck_p & ~cs_idle;
  assign sck_fall = ~sck_ff[STAGES-1] & sck_p & ~cs_idle;
endmodule

// File: rtl/spi_mem_shift.sv
module spi_mem_shift
  import spi_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sck_rise,
  input  logic              si,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              bit_zero,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);
  logic [BYTE_W-2:0] rx;

  assign rx_byte   = {rx, si};
  assign byte_done = sck_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
  assign bit_zero  = (bit_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx      <= '0;
    end else if (clr) begin
      bit_cnt <= '0;
      rx      <= '0;
    end else if (sck_rise) begin
      bit_cnt <= bit_cnt + 1'b1;
      rx      <= rx_byte[BYTE_W-2:0];
    end
  end
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_BITS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_idle,
  input  logic              sck_fall,
  input  logic              bit_zero,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              so,
  output logic              so_oe,
  output logic              wel,
  output logic              mem_we,
  output logic              st_lock
);
  localparam int DEPTH = 1 << ADDR_BITS;

  cmd_state_e           st;
  logic [ADDR_BITS-1:0] addr;
  logic [7:0]           ahi;
  logic                 rd_cmd;
  logic                 pend_clr;
  logic [1:0]           guard;
  logic                 flag7;
  logic [BYTE_W-1:0]    tx;
  logic [BYTE_W-1:0]    mem [DEPTH];
  logic [BYTE_W-1:0]    sr_word;
  logic [15:0]          full_addr;
  logic                 tx_load;

  function automatic logic [ADDR_BITS-1:0] step_addr(input logic [ADDR_BITS-1:0] a);
    step_addr = a + 1'b1;
  endfunction

  assign sr_word   = {flag7, 3'b000, guard, wel, 1'b0};
  assign full_addr = {ahi, rx_byte};
  assign st_lock   = (st == ST_LOCK);
  assign mem_we    = byte_done && (st == ST_WR) && wel &&
                     !block_hit(guard, addr[ADDR_BITS-1 -: 2]);
  assign tx_load   = sck_fall && bit_zero && ((st == ST_RD) || (st == ST_SROUT));
  assign so        = tx[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (mem_we) mem[addr] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_CMD;
      addr     <= '0;
      ahi      <= '0;
      rd_cmd   <= 1'b0;
      pend_clr <= 1'b0;
      wel      <= 1'b0;
      guard    <= 2'b00;
      flag7    <= 1'b0;
      tx       <= '0;
      so_oe    <= 1'b0;
    end else if (cs_idle) begin
      st    <= ST_CMD;
      so_oe <= 1'b0;
      if (pend_clr) begin
        wel      <= 1'b0;
        pend_clr <= 1'b0;
      end
    end else begin
      if (byte_done) begin
        case (st)
          ST_CMD: begin
            case (rx_byte)
              OP_WREN: begin wel <= 1'b1; st <= ST_IDLE; end
              OP_WRDI: begin wel <= 1'b0; st <= ST_IDLE; end
              OP_RDSR: st <= ST_SROUT;
              OP_WRSR: st <= ST_WRSR;
              OP_READ: begin rd_cmd <= 1'b1; st <= ST_AHI; end
              OP_WRIT: begin rd_cmd <= 1'b0; st <= ST_AHI; end
              default: st <= ST_LOCK;
            endcase
          end
          ST_AHI: begin
            ahi <= rx_byte;
            st  <= ST_ALO;
          end
          ST_ALO: begin
            addr <= ADDR_BITS'(full_addr);
            st   <= rd_cmd ? ST_RD : ST_WR;
          end
          ST_WR: begin
            addr <= step_addr(addr);
            if (wel) pend_clr <= 1'b1;
          end
          ST_WRSR: begin
            if (wel) begin
              flag7    <= rx_byte[7];
              guard    <= rx_byte[3:2];
              pend_clr <= 1'b1;
            end
            st <= ST_IDLE;
          end
          default: ;
        endcase
      end
      if (tx_load) begin
        so_oe <= 1'b1;
        if (st == ST_RD) begin
          tx   <= mem[addr];
          addr <= step_addr(addr);
        end else begin
          tx <= sr_word;
        end
      end else if (sck_fall && so_oe) begin
        tx <= {tx[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_BITS   = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic so,
  output logic so_oe
);
  logic              sck_rise;
  logic              sck_fall;
  logic              cs_idle;
  logic              si_s;
  logic [CNT_W-1:0]  bit_cnt;
  logic              bit_zero;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic              wel;
  logic              mem_we;
  logic              st_lock;

  spi_mem_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_i    (sck),
    .cs_n_i   (cs_n),
    .si_i     (si),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_idle  (cs_idle),
    .si_s     (si_s)
  );

  spi_mem_shift i_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cs_idle),
    .sck_rise  (sck_rise),
    .si        (si_s),
    .bit_cnt   (bit_cnt),
    .bit_zero  (bit_zero),
    .byte_done (byte_done),
    .rx_byte   (rx_byte)
  );

  spi_mem_ctrl #(.ADDR_BITS(ADDR_BITS)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_idle   (cs_idle),
    .sck_fall  (sck_fall),
    .bit_zero  (bit_zero),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .so        (so),
    .so_oe     (so_oe),
    .wel       (wel),
    .mem_we    (mem_we),
    .st_lock   (st_lock)
  );
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_idle,
  input logic       so,
  input logic       so_oe,
  input logic       sck_fall,
  input logic       byte_done,
  input logic [2:0] bit_cnt,
  input logic       wel,
  input logic       mem_we,
  input logic       st_lock
);
  a_r9_lock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    st_lock |-> !so_oe);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (!so_oe && bit_cnt == 3'd0));

  a_r5_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sck_fall) |-> $stable(so));

  a_r4_wel_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(byte_done));

  a_r6_commit_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wel);

  a_r2_byte_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> bit_cnt == 3'd0);
endmodule

bind spi_mem_slave spi_mem_slave_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_idle   (cs_idle),
  .so        (so),
  .so_oe     (so_oe),
  .sck_fall  (sck_fall),
  .byte_done (byte_done),
  .bit_cnt   (bit_cnt),
  .wel       (wel),
  .mem_we    (mem_we),
  .st_lock   (st_lock)
);

// File: tb/test_spi_mem_slave.sv
module test_spi_mem_slave;
  localparam int AB = 4;
  localparam int DEP = 1 << AB;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n, sck, cs_n, si;
  logic so, so_oe;
  logic mode3;
  int   n_chk = 0;
  int   n_fail = 0;

  logic [7:0] exp_mem [DEP];
  logic       m_wel;
  logic [1:0] m_bp;
  logic       m_b7;

  always #2 clk = ~clk;

  spi_mem_slave #(.ADDR_BITS(AB), .SYNC_STAGES(2)) i_spi_mem_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe)
  );

  function automatic logic [7:0] sr_model();
    return {m_b7, 3'b000, m_bp, m_wel, 1'b0};
  endfunction

  function automatic logic prot(input logic [1:0] bp, input int a);
    return (bp == 2'd3) || (bp == 2'd2 && a >= DEP / 2) || (bp == 2'd1 && a >= 3 * DEP / 4);
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 13) + (i * 29) + 7);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx,
                      output logic oe_any, output logic oe_all);
    rx = 8'h00; oe_any = 1'b0; oe_all = 1'b1;
    for (int b = 7; b > 7 - nbits; b--) begin
      if (mode3) sck = 1'b0;
      si = tx[b];
      repeat (H) @(negedge clk);
      rx[b] = so;
      oe_any |= so_oe;
      oe_all &= so_oe;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic cs_start();
    sck = mode3;
    repeat (H) @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_stop();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic simple_cmd(input logic [7:0] op);
    logic [7:0] r; logic a, b;
    cs_start(); xfer(op, 8, r, a, b); cs_stop();
    if (op == 8'h06) m_wel = 1'b1;
    if (op == 8'h04) m_wel = 1'b0;
  endtask

  task automatic read_sr(input string req);
    logic [7:0] r1, r2; logic a, b;
    cs_start();
    xfer(8'h05, 8, r1, a, b);
    xfer(8'h00, 8, r1, a, b);
    chk(req, {31'd0, b}, 32'd1);
    xfer(8'h00, 8, r2, a, b);
    cs_stop();
    chk(req, {24'd0, r1}, {24'd0, sr_model()});
    chk({req, " repeat"}, {24'd0, r2}, {24'd0, sr_model()});
  endtask

  task automatic write_sr(input logic [7:0] v);
    logic [7:0] r; logic a, b;
    cs_start(); xfer(8'h01, 8, r, a, b); xfer(v, 8, r, a, b); cs_stop();
    if (m_wel) begin m_b7 = v[7]; m_bp = v[3:2]; m_wel = 1'b0; end
  endtask

  task automatic write_block(input logic [15:0] a16, input int n, input int seed);
    logic [7:0] r; logic a, b;
    int ad = int'(a16) % DEP;
    cs_start();
    xfer(8'h02, 8, r, a, b); xfer(a16[15:8], 8, r, a, b); xfer(a16[7:0], 8, r, a, b);
    for (int i = 0; i < n; i++) begin
      xfer(pat(seed, i), 8, r, a, b);
      if (m_wel && !prot(m_bp, ad)) exp_mem[ad] = pat(seed, i);
      ad = (ad + 1) % DEP;
    end
    cs_stop();
    if (n > 0) m_wel = 1'b0;
  endtask

  task automatic read_check(input logic [15:0] a16, input int n, input string req);
    logic [7:0] r; logic a, b;
    int ad = int'(a16) % DEP;
    cs_start();
    xfer(8'h03, 8, r, a, b); xfer(a16[15:8], 8, r, a, b); xfer(a16[7:0], 8, r, a, b);
    chk({req, " oe off during address"}, {31'd0, a}, 32'd0);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, 8, r, a, b);
      chk(req, {24'd0, r}, {24'd0, exp_mem[ad]});
      chk({req, " oe"}, {31'd0, b}, 32'd1);
      ad = (ad + 1) % DEP;
    end
    cs_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r; logic a, b, anyoe;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; mode3 = 1'b0;
    m_wel = 1'b0; m_bp = 2'b00; m_b7 = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 so_oe idle", {31'd0, so_oe}, 32'd0);
    read_sr("R1 status after reset");

    simple_cmd(8'h06); read_sr("R2 WREN sets latch");
    mode3 = 1'b1;
    simple_cmd(8'h04); read_sr("R2/R11 WRDI clears latch");

    simple_cmd(8'h06);
    write_block(16'h0000, DEP, 1);
    mode3 = 1'b0;
    read_check(16'hFFF0, DEP + 4, "R5/R7 read fill with wrap");
    read_sr("R4 latch cleared after write");

    write_block(16'h0003, 2, 2);
    mode3 = 1'b1;
    read_check(16'h0003, 2, "R6/R11 write ignored without latch");

    simple_cmd(8'h06);
    write_block(16'hF00E, 4, 3);
    read_check(16'h000E, 4, "R7 write wraps");

    write_sr(8'hFF); read_sr("R3 status write ignored without latch");
    simple_cmd(8'h06); write_sr(8'hFF); read_sr("R3/R4 status write mask");

    for (int bp = 0; bp < 4; bp++) begin
      mode3 = bp[0];
      simple_cmd(8'h06); write_sr({6'd0, 2'(bp)} << 2);
      simple_cmd(8'h06); write_block(16'h0000, DEP, 10 + bp);
      read_check(16'h0000, DEP, "R8 protect sweep");
    end
    simple_cmd(8'h06); write_sr(8'h00); read_sr("R3 status restore");

    mode3 = 1'b0;
    cs_start();
    xfer(8'h55, 8, r, a, b); anyoe = a;
    xfer(8'h06, 8, r, a, b); anyoe |= a;
    xfer(8'h03, 8, r, a, b); anyoe |= a;
    for (int i = 0; i < 3; i++) begin xfer(8'h00, 8, r, a, b); anyoe |= a; end
    cs_stop();
    chk("R9 so_oe stays low after bad opcode", {31'd0, anyoe}, 32'd0);
    read_sr("R9 later bytes ignored");
    read_check(16'h0001, 2, "R9 next select works");

    mode3 = 1'b1;
    simple_cmd(8'h06);
    cs_start();
    xfer(8'h02, 8, r, a, b); xfer(8'h00, 8, r, a, b); xfer(8'h05, 8, r, a, b);
    xfer(8'h3C, 8, r, a, b); xfer(8'hFF, 4, r, a, b);
    cs_stop();
    if (!prot(m_bp, 5)) exp_mem[5] = 8'h3C;
    m_wel = 1'b0;
    read_check(16'h0005, 2, "R10 partial byte dropped");
    read_sr("R10 latch after aborted write");

    cs_start();
    xfer(8'h03, 8, r, a, b); xfer(8'h00, 8, r, a, b); xfer(8'h07, 8, r, a, b);
    xfer(8'h00, 3, r, a, b);
    chk("R10 oe during aborted read", {31'd0, a}, 32'd1);
    cs_stop();
    chk("R10 oe off after abort", {31'd0, so_oe}, 32'd0);
    read_check(16'h0007, 1, "R10 fresh command after abort");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule